// File: doc/BRIEF.md
# NAND Program-Order Guard

This block sits between a host command port and a NAND array model and keeps a small record for every erase block. For each block it holds whether any page has been programmed since the last erase, the highest page programmed so far, and how many erase cycles the block has taken. Every host command (read a page, program a page, erase a block) is checked against the flash write rules. An accepted command is passed to a downstream command port with a valid/ready handshake. A rejected command is dropped and only reported back.

Programs within a block must move to strictly higher page indices. Skipped pages are allowed, going back is not, and only an erase starts the order again. Every erase adds one to the block's wear count. Once the count reaches the erase-cycle limit the block is worn out, and from then on it refuses erases and programs. The per-block records sit in a RAM that can be inferred as block RAM. After reset the block sweeps that RAM clear before it takes any command.

Top module: `nand_order_guard`

## Requirements
- R1: After reset, `cmd_ready` stays low for 2**BLK_W cycles while the state RAM is cleared. Every block then reads as erased, with no page programmed and a wear count of zero.
- R2: The first program after an erase (or after reset) is accepted for any in-range page index, including indices other than 0. It returns status 2'b00 (OK) and is forwarded.
- R3: Programs within one block to strictly increasing page indices are each accepted, with or without gaps (for example pages 1, 5, 8).
- R4: A program to a page index lower than the block's highest programmed page returns status 2'b10 (out of order). It is not forwarded and it leaves the block state unchanged.
- R5: A program to the block's highest programmed page returns status 2'b01 (not erased). It is not forwarded and it leaves the block state unchanged.
- R6: An erase of a block that is not worn out returns OK and is forwarded. It clears the block's page order, so any page may follow, and it adds one to the block's wear count.
- R7: A block whose wear count has reached WEAR_LIMIT answers both erase and program with status 2'b11 (worn out). Nothing is forwarded and the state does not change. WEAR_LIMIT defaults to 100000 when CELL_BITS=1 and to 10000 otherwise.
- R8: A read (op 2'b00) to an in-range block and page is always accepted and forwarded, also on a worn-out block. It never changes the block's state.
- R9: A command with block index ≥ NUM_BLOCKS, page index ≥ PAGES, or the reserved op code 2'b11 returns status 2'b10 and is not forwarded. Op codes: 2'b00 read, 2'b01 program, 2'b10 erase.
- R10: Each accepted host handshake produces exactly one `rsp_valid` pulse of one cycle, two clock edges after the handshake edge.
- R11: `dn_valid` rises together with an OK response. It holds with stable `dn_op`, `dn_blk` and `dn_page` until `dn_ready`, and `cmd_ready` stays low while it is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Guard can take a host command |
| cmd_op | input | 2 | Operation: 00 read, 01 program, 10 erase, 11 reserved |
| cmd_blk | input | BLK_W | Erase-block index |
| cmd_page | input | PAGE_W | Page index within the block |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 00 OK, 01 not erased, 10 out of order, 11 worn out |
| dn_valid | output | 1 | Forwarded command present |
| dn_ready | input | 1 | Downstream takes the forwarded command |
| dn_op | output | 2 | Forwarded operation |
| dn_blk | output | BLK_W | Forwarded block index |
| dn_page | output | PAGE_W | Forwarded page index |

## Verification
The assertions assume two things about the inputs. The host keeps its command fields steady in the cycle it raises `cmd_valid`. The downstream side eventually raises `dn_ready`, so a forwarded command cannot pin `cmd_ready` low forever. The stimulus drives each command for exactly one handshake and changes inputs only on falling edges. It pulses `dn_ready` after a chosen stall of zero or more cycles, which keeps both assumptions true throughout the run. WEAR_LIMIT is lowered so that the worn-out boundary is reached after a few erases.

// File: rtl/nog_pkg.sv
package nog_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } nog_op_e;

  typedef enum logic [1:0] {
    ST_OK         = 2'b00,
    ST_NOT_ERASED = 2'b01,
    ST_ORDER      = 2'b10,
    ST_WORN       = 2'b11
  } nog_status_e;

  typedef enum logic [1:0] {
    S_INIT,
    S_IDLE,
    S_EVAL,
    S_FWD
  } nog_fsm_e;

endpackage

// File: rtl/nog_state_ram.sv
// Simple dual-port record store, synchronous read, written for block RAM inference.
module nog_state_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nog_rule_check.sv
// Decides the status of one command against its block record and builds the next record.
module nog_rule_check
  import nog_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int PAGES      = 64,
  parameter int BLK_W      = 4,
  parameter int PAGE_W     = 7,
  parameter int WEAR_LIMIT = 100000,
  parameter int WEAR_W     = 17
) (
  input  logic [1:0]        op,
  input  logic [BLK_W-1:0]  blk,
  input  logic [PAGE_W-1:0] page,
  input  logic              st_prog,
  input  logic [PAGE_W-1:0] st_last,
  input  logic [WEAR_W-1:0] st_wear,
  output logic [1:0]        status,
  output logic              pass,
  output logic              wr_en,
  output logic              nxt_prog,
  output logic [PAGE_W-1:0] nxt_last,
  output logic [WEAR_W-1:0] nxt_wear
);
  localparam logic [BLK_W:0]    BLK_LIM  = (BLK_W+1)'(NUM_BLOCKS);
  localparam logic [PAGE_W:0]   PAGE_LIM = (PAGE_W+1)'(PAGES);
  localparam logic [WEAR_W-1:0] WEAR_LIM = WEAR_W'(WEAR_LIMIT);

  logic        in_range;
  logic        worn;
  nog_status_e st;

  always_comb begin
    in_range = ({1'b0, blk} < BLK_LIM) && ({1'b0, page} < PAGE_LIM);
    worn     = (st_wear >= WEAR_LIM);
    st       = ST_OK;
    pass     = 1'b0;
    wr_en    = 1'b0;
    nxt_prog = st_prog;
    nxt_last = st_last;
    nxt_wear = st_wear;
    if (!in_range) begin
      st = ST_ORDER;
    end else begin
      case (nog_op_e'(op))
        OP_READ: pass = 1'b1;
        OP_PROG: begin
          if (worn)                           st = ST_WORN;
          else if (st_prog && page == st_last) st = ST_NOT_ERASED;
          else if (st_prog && page <  st_last) st = ST_ORDER;
          else begin
            pass     = 1'b1;
            wr_en    = 1'b1;
            nxt_prog = 1'b1;
            nxt_last = page;
          end
        end
        OP_ERASE: begin
          if (worn) st = ST_WORN;
          else begin
            pass     = 1'b1;
            wr_en    = 1'b1;
            nxt_prog = 1'b0;
            nxt_last = '0;
            nxt_wear = st_wear + WEAR_W'(1);
          end
        end
        default: st = ST_ORDER;
      endcase
    end
    status = st;
  end
endmodule

// File: rtl/nog_fwd_reg.sv
// Output register for the downstream command port.
module nog_fwd_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nand_order_guard.sv
module nand_order_guard
  import nog_pkg::*;
#(
  parameter int NUM_BLOCKS = 12,
  parameter int PAGES      = 64,
  parameter int BLK_W      = 4,
  parameter int PAGE_W     = 7,
  parameter int CELL_BITS  = 1,
  parameter int WEAR_LIMIT = (CELL_BITS == 1) ? 100000 : 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [PAGE_W-1:0] cmd_page,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [1:0]        dn_op,
  output logic [BLK_W-1:0]  dn_blk,
  output logic [PAGE_W-1:0] dn_page
);
  localparam int WEAR_W = $clog2(WEAR_LIMIT + 1);
  localparam int ENT_W  = 1 + PAGE_W + WEAR_W;
  localparam int FWD_W  = 2 + BLK_W + PAGE_W;

  nog_fsm_e          state;
  logic [BLK_W-1:0]  init_cnt;
  logic [1:0]        cur_op;
  logic [BLK_W-1:0]  cur_blk;
  logic [PAGE_W-1:0] cur_page;

  logic              ram_we;
  logic [BLK_W-1:0]  ram_waddr;
  logic [ENT_W-1:0]  ram_wdata;
  logic [ENT_W-1:0]  ram_rdata;

  logic              st_prog;
  logic [PAGE_W-1:0] st_last;
  logic [WEAR_W-1:0] st_wear;
  logic [1:0]        chk_status;
  logic              chk_pass;
  logic              chk_wr;
  logic              nx_prog;
  logic [PAGE_W-1:0] nx_last;
  logic [WEAR_W-1:0] nx_wear;

  logic              fwd_load;
  logic [FWD_W-1:0]  fwd_data;

  assign cmd_ready = (state == S_IDLE);
  assign {st_prog, st_last, st_wear} = ram_rdata;

  always_comb begin
    if (state == S_INIT) begin
      ram_we    = 1'b1;
      ram_waddr = init_cnt;
      ram_wdata = '0;
    end else begin
      ram_we    = (state == S_EVAL) && chk_wr;
      ram_waddr = cur_blk;
      ram_wdata = {nx_prog, nx_last, nx_wear};
    end
  end

  assign fwd_load = (state == S_EVAL) && chk_pass;

  nog_state_ram #(
    .ADDR_W (BLK_W),
    .DATA_W (ENT_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (cmd_blk),
    .rdata (ram_rdata)
  );

  nog_rule_check #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .PAGES      (PAGES),
    .BLK_W      (BLK_W),
    .PAGE_W     (PAGE_W),
    .WEAR_LIMIT (WEAR_LIMIT),
    .WEAR_W     (WEAR_W)
  ) u_rule (
    .op       (cur_op),
    .blk      (cur_blk),
    .page     (cur_page),
    .st_prog  (st_prog),
    .st_last  (st_last),
    .st_wear  (st_wear),
    .status   (chk_status),
    .pass     (chk_pass),
    .wr_en    (chk_wr),
    .nxt_prog (nx_prog),
    .nxt_last (nx_last),
    .nxt_wear (nx_wear)
  );

  nog_fwd_reg #(
    .W (FWD_W)
  ) u_fwd (
    .clk       (clk),
    .rst       (rst),
    .load      (fwd_load),
    .load_data ({cur_op, cur_blk, cur_page}),
    .ready     (dn_ready),
    .valid     (dn_valid),
    .data      (fwd_data)
  );

  assign {dn_op, dn_blk, dn_page} = fwd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_INIT;
      init_cnt   <= '0;
      cur_op     <= '0;
      cur_blk    <= '0;
      cur_page   <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_INIT: begin
          init_cnt <= init_cnt + BLK_W'(1);
          if (init_cnt == '1) state <= S_IDLE;
        end
        S_IDLE: begin
          if (cmd_valid) begin
            cur_op   <= cmd_op;
            cur_blk  <= cmd_blk;
            cur_page <= cmd_page;
            state    <= S_EVAL;
          end
        end
        S_EVAL: begin
          rsp_valid  <= 1'b1;
          rsp_status <= chk_status;
          state      <= chk_pass ? S_FWD : S_IDLE;
        end
        S_FWD: begin
          if (dn_valid && dn_ready) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nog_checker.sv
module nog_checker #(
  parameter int BLK_W  = 4,
  parameter int PAGE_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [1:0]        dn_op,
  input logic [BLK_W-1:0]  dn_blk,
  input logic [PAGE_W-1:0] dn_page
);
  // R1: the clearing sweep keeps the host port closed right after reset
  p_init_busy_r1: assert property (@(posedge clk) rst |=> !cmd_ready);

  // R10: response is a single-cycle strobe
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R10: response arrives two edges after the handshake
  p_rsp_after_hs_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> ##1 rsp_valid);

  // R4: only an OK response comes with a forwarded command
  p_fwd_on_ok_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (dn_valid == (rsp_status == 2'b00)));

  // R11: a pending forward holds its fields
  p_dn_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_op) && $stable(dn_blk) && $stable(dn_page)));

  // R11: host port is closed while a forward is pending
  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !dn_valid);

  // R9: reserved op code never reaches the downstream port
  p_no_rsvd_r9: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> (dn_op != 2'b11));
endmodule

bind nand_order_guard nog_checker #(
  .BLK_W  (BLK_W),
  .PAGE_W (PAGE_W)
) u_nog_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .dn_valid   (dn_valid),
  .dn_ready   (dn_ready),
  .dn_op      (dn_op),
  .dn_blk     (dn_blk),
  .dn_page    (dn_page)
);

// File: tb/sim_nand_order_guard.sv
`timescale 1ns/1ps
module sim_nand_order_guard;
  localparam int NB     = 12;
  localparam int NP     = 64;
  localparam int BLK_W  = 4;
  localparam int PAGE_W = 7;
  localparam int LIM    = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [1:0]        cmd_op = '0;
  logic [BLK_W-1:0]  cmd_blk = '0;
  logic [PAGE_W-1:0] cmd_page = '0;
  logic              rsp_valid;
  logic [1:0]        rsp_status;
  logic              dn_valid;
  logic              dn_ready = 1'b0;
  logic [1:0]        dn_op;
  logic [BLK_W-1:0]  dn_blk;
  logic [PAGE_W-1:0] dn_page;

  always #2.5 clk = ~clk;

  nand_order_guard #(
    .NUM_BLOCKS (NB),
    .PAGES      (NP),
    .BLK_W      (BLK_W),
    .PAGE_W     (PAGE_W),
    .WEAR_LIMIT (LIM)
  ) u0 (
    .clk (clk), .rst (rst),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_op (cmd_op), .cmd_blk (cmd_blk), .cmd_page (cmd_page),
    .rsp_valid (rsp_valid), .rsp_status (rsp_status),
    .dn_valid (dn_valid), .dn_ready (dn_ready),
    .dn_op (dn_op), .dn_blk (dn_blk), .dn_page (dn_page)
  );

  int nchk = 0;
  int nerr = 0;
  int n_cmds = 0;
  int n_rsp = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit m_prog [NB];
  int m_last [NB];
  int m_wear [NB];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin
      m_prog[i] = 1'b0; m_last[i] = 0; m_wear[i] = 0;
    end
  endtask

  // returns expected status and applies the accepted effect
  function automatic int model_step(input int op, input int blk, input int page);
    if (blk >= NB || page >= NP || op == 3) return 2;
    if (op == 0) return 0;
    if (m_wear[blk] >= LIM) return 3;
    if (op == 1) begin
      if (m_prog[blk] && page == m_last[blk]) return 1;
      if (m_prog[blk] && page <  m_last[blk]) return 2;
      m_prog[blk] = 1'b1; m_last[blk] = page;
      return 0;
    end
    m_prog[blk] = 1'b0; m_last[blk] = 0; m_wear[blk]++;
    return 0;
  endfunction

  // per-clock monitor: response counting and forward stability
  logic [1:0]        p_op;
  logic [BLK_W-1:0]  p_blk;
  logic [PAGE_W-1:0] p_page;
  bit                p_hold = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) n_rsp++;
      if (p_hold) check(dn_valid && dn_op == p_op && dn_blk == p_blk && dn_page == p_page,
                        "R11 hold", int'(dn_valid), 1);
      if (dn_valid && cmd_ready) check(1'b0, "R11 ready-while-pending", 1, 0);
      p_hold = dn_valid && !dn_ready;
      p_op = dn_op; p_blk = dn_blk; p_page = dn_page;
    end else p_hold = 1'b0;
  end

  task automatic do_reset();
    int low;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!rsp_valid && !dn_valid, "R1 outputs idle in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    model_reset();
    low = 0;
    while (!cmd_ready && low < 100) begin
      low++;
      @(negedge clk);
    end
    check(low == (1 << BLK_W), "R1 sweep length", low, 1 << BLK_W);
  endtask

  task automatic send(input int op, input int blk, input int page, input int stall, input string req);
    int exp;
    exp = model_step(op, blk, page);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = 2'(op); cmd_blk = BLK_W'(blk); cmd_page = PAGE_W'(page);
    n_cmds++;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(!rsp_valid, {req, " R10 no early response"}, int'(rsp_valid), 0);
    @(negedge clk);
    check(rsp_valid, {req, " R10 response strobe"}, int'(rsp_valid), 1);
    check(rsp_status == 2'(exp), {req, " status"}, int'(rsp_status), exp);
    check(dn_valid == (exp == 0), {req, " forward"}, int'(dn_valid), int'(exp == 0));
    if (exp == 0) begin
      check(dn_op == 2'(op) && dn_blk == BLK_W'(blk) && dn_page == PAGE_W'(page),
            {req, " R11 forwarded fields"}, int'(dn_page), page);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check(dn_valid && !cmd_ready, {req, " R11 stall"}, int'(dn_valid), 1);
      end
      dn_ready = 1'b1;
      @(negedge clk);
      dn_ready = 1'b0;
      check(!dn_valid, {req, " R11 forward taken"}, int'(dn_valid), 0);
    end
  endtask

  initial begin
    do_reset();
    // R2: first program may land on any page
    send(1, 0, 1, 0, "R2 first page 1");
    send(1, 1, 0, 0, "R2 first page 0");
    send(1, 2, 63, 2, "R2 first page 63");
    // R3: ascending with gaps
    send(1, 0, 5, 1, "R3 page 5");
    send(1, 0, 8, 0, "R3 page 8");
    // R4: going back
    send(1, 0, 5, 0, "R4 back to 5");
    send(1, 0, 2, 0, "R4 back to 2");
    // R5: rewriting the last page
    send(1, 0, 8, 0, "R5 rewrite 8");
    send(1, 2, 63, 0, "R5 rewrite 63");
    send(1, 0, 9, 0, "R3 page 9");
    // R8: reads forward and leave state alone
    send(0, 0, 3, 3, "R8 read");
    send(1, 0, 9, 0, "R8 state kept");
    send(1, 0, 10, 0, "R8 order kept");
    // R9: range and reserved op
    send(1, 12, 0, 0, "R9 block range");
    send(0, 15, 0, 0, "R9 read block range");
    send(1, 3, 64, 0, "R9 page range");
    send(3, 0, 20, 0, "R9 reserved op");
    send(1, 0, 11, 0, "R9 state kept");
    // R6: erase restarts order
    send(2, 0, 0, 1, "R6 erase");
    send(1, 0, 2, 0, "R6 low page after erase");
    send(1, 0, 1, 0, "R4 after erase");
    // R7: wear limit
    send(2, 3, 0, 0, "R6 wear 1");
    send(1, 3, 7, 0, "R6 program");
    send(2, 3, 0, 0, "R6 wear 2");
    send(2, 3, 0, 0, "R7 wear reaches limit");
    send(2, 3, 0, 0, "R7 erase worn");
    send(1, 3, 0, 0, "R7 program worn");
    send(0, 3, 4, 0, "R7 read worn");
    send(2, 3, 0, 0, "R7 still worn");
    repeat (2) @(negedge clk);
    check(n_rsp == n_cmds, "R10 response count", n_rsp, n_cmds);
    // R1: reset clears wear and order
    do_reset();
    n_rsp = 0; n_cmds = 0;
    send(1, 3, 0, 0, "R1 worn block cleared");
    send(1, 0, 0, 0, "R1 order cleared");
    send(2, 3, 0, 0, "R1 wear cleared");
    repeat (2) @(negedge clk);
    check(n_rsp == n_cmds, "R10 response count after reset", n_rsp, n_cmds);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule